// File: doc/BRIEF.md
# Multi-Memory Self-Test and Repair Sequencer

This block coordinates self-test and repair for a group of embedded memories of unequal size. On a start request it fires every memory's March-style test engine together and gathers, per memory, a fail flag and a fault count. A memory whose count is larger than the total number of spare rows plus spare columns is marked beyond repair straight away.

If any memory failed, a second pass follows. The failing memories that still have a chance of repair are re-tested one at a time, and each one's fault stream is steered to a single shared repair analyzer. The largest memory is served first. Memory sizes are fixed parameters, so the service order is worked out at elaboration time. The analyzer's verdict for each memory is kept, and a one-cycle done pulse closes the run. Test engines and analyzer are external and are reached through start pulses and done pulses.

Top module: `mbs_sched`

## Requirements
- R1: One cycle after `start` is sampled high while the block is idle, `eng_start` is all ones for exactly one cycle, and `eng_start` does not pulse all ones again in that run.
- R2: In the first pass, the first `eng_done[i]` pulse latches `eng_fail[i]` and, for a failing memory, `eng_fault_cnt` slice i. At the end of the run `st_pass[i]` is the inverse of that latched fail flag, and `st_fault_cnt` slice i holds the count, or zero for a passing memory.
- R3: A failing memory whose count is greater than SPARE_ROWS+SPARE_COLS is never re-tested and reports `st_irrep[i]`=1. A count equal to that total is still re-tested.
- R4: When no memory fails, `done` pulses with `all_pass`=1 and no second-pass start occurs.
- R5: Second-pass starts go only to failing, not-yet-irreparable memories, in descending order of MEM_WORDS, with equal sizes served lower index first.
- R6: Each second-pass start raises exactly one `eng_start` bit together with `ana_start`, and `ana_sel` carries that memory's index.
- R7: After `ana_done`, `ana_ok`=1 sets `st_repaired[i]` and `ana_ok`=0 sets `st_irrep[i]` for the memory being served. The block moves on only after that memory's engine done and then `ana_done`.
- R8: `done` is high for exactly one cycle per run. `start` during a run is ignored, and a new run clears all status outputs.
- R9: An `eng_done` pulse from a memory that is not being served in the second pass has no effect on order or results.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start | input | 1 | Run request, sampled only when idle |
| eng_start | output | N_MEM | Start pulse per test engine |
| eng_done | input | N_MEM | Done pulse per test engine |
| eng_fail | input | N_MEM | Engine found faults, valid with its done |
| eng_fault_cnt | input | N_MEM*CNT_W | Fault count per engine, slice i for memory i |
| ana_start | output | 1 | Start pulse to the shared analyzer |
| ana_sel | output | IDX_W | Memory whose fault stream goes to the analyzer |
| ana_done | input | 1 | Analyzer finished |
| ana_ok | input | 1 | Analyzer found a repair, valid with ana_done |
| done | output | 1 | One-cycle end-of-run pulse |
| all_pass | output | 1 | Last run found no failing memory |
| st_pass | output | N_MEM | Memory passed the first pass |
| st_repaired | output | N_MEM | Memory has a repair solution |
| st_irrep | output | N_MEM | Memory cannot be repaired |
| st_fault_cnt | output | N_MEM*CNT_W | Latched fault count per memory |

## Verification
The parallel launch of the first pass appears on `eng_start` in the cycle after `start` is registered. The bench raises `start` just after a rising edge and expects the all-ones pattern at the second falling edge. Each second-pass launch is combinational from the registered state, so it is sampled at falling edges and compared in order against a service list the bench sorts from the sizes alone. Statuses and `all_pass` are registered and stable once `done` is seen, so they are checked in that cycle. The width of `done` is counted over the following cycles.

// File: rtl/mbs_pkg.sv
package mbs_pkg;
   typedef enum logic [3:0] {
      ST_IDLE,
      ST_P1_GO,
      ST_P1_WAIT,
      ST_EVAL,
      ST_PICK,
      ST_P2_GO,
      ST_P2_ENG,
      ST_P2_ANA,
      ST_DONE
   } sched_st_e;
endpackage

// File: rtl/mbs_order.sv
// Elaboration-time service order: position p -> memory index, largest first.
module mbs_order #(
   parameter int          N_MEM = 4,
   parameter int          IDX_W = 2,
   parameter int unsigned MEM_WORDS [N_MEM] = '{256, 1024, 512, 1024}
) (
   output logic [N_MEM-1:0][IDX_W-1:0] order_idx
);
   function automatic int rank_of(int i);
      int r = 0;
      for (int j = 0; j < N_MEM; j++) begin
         if (MEM_WORDS[j] > MEM_WORDS[i] ||
             (MEM_WORDS[j] == MEM_WORDS[i] && j < i)) r++;
      end
      return r;
   endfunction

   function automatic int idx_at(int p);
      int found = 0;
      for (int i = 0; i < N_MEM; i++) begin
         if (rank_of(i) == p) found = i;
      end
      return found;
   endfunction

   for (genvar p = 0; p < N_MEM; p++) begin : g_pos
      if (MEM_WORDS[p] == 0) begin : g_bad_size
         $error("mbs_order: memory size must be non-zero");
      end
      assign order_idx[p] = IDX_W'(idx_at(p));
   end
endmodule

// File: rtl/mbs_collect.sv
// First-pass capture of fail flag and fault count per memory.
module mbs_collect #(
   parameter int N_MEM  = 4,
   parameter int CNT_W  = 8,
   parameter int SPARES = 6
) (
   input  logic                         clk,
   input  logic                         rst_n,
   input  logic                         clr,
   input  logic                         capture,
   input  logic [N_MEM-1:0]             eng_done,
   input  logic [N_MEM-1:0]             eng_fail,
   input  logic [N_MEM-1:0][CNT_W-1:0]  eng_cnt,
   output logic [N_MEM-1:0]             seen,
   output logic [N_MEM-1:0]             fail,
   output logic [N_MEM-1:0]             over,
   output logic [N_MEM-1:0][CNT_W-1:0]  cnt,
   output logic                         all_seen
);
   for (genvar i = 0; i < N_MEM; i++) begin : g_mem
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) begin
            seen[i] <= 1'b0;
            fail[i] <= 1'b0;
            cnt[i]  <= '0;
         end else if (clr) begin
            seen[i] <= 1'b0;
            fail[i] <= 1'b0;
            cnt[i]  <= '0;
         end else if (capture && eng_done[i] && !seen[i]) begin
            seen[i] <= 1'b1;
            fail[i] <= eng_fail[i];
            cnt[i]  <= eng_fail[i] ? eng_cnt[i] : '0;
         end
      end
      assign over[i] = fail[i] && (int'(cnt[i]) > SPARES);

      // R2: a latched result does not move while capture stays open
      a_r2_hold_result: assert property (@(posedge clk) disable iff (!rst_n)
         (seen[i] && !clr) |=> ($stable(cnt[i]) && $stable(fail[i])));
   end
   assign all_seen = &seen;
endmodule

// File: rtl/mbs_ctrl.sv
// Run sequencer: parallel first pass, ordered serial second pass.
module mbs_ctrl
   import mbs_pkg::*;
#(
   parameter int N_MEM = 4,
   parameter int IDX_W = 2
) (
   input  logic                         clk,
   input  logic                         rst_n,
   input  logic                         start,
   input  logic                         all_seen,
   input  logic [N_MEM-1:0]             fail,
   input  logic [N_MEM-1:0]             over,
   input  logic [N_MEM-1:0][IDX_W-1:0]  order_idx,
   input  logic [N_MEM-1:0]             eng_done,
   input  logic                         ana_done,
   input  logic                         ana_ok,
   output logic                         clr,
   output logic                         capture,
   output logic [N_MEM-1:0]             eng_start,
   output logic                         ana_start,
   output logic [IDX_W-1:0]             ana_sel,
   output logic                         done,
   output logic                         all_pass,
   output logic [N_MEM-1:0]             rep,
   output logic [N_MEM-1:0]             irr
);
   localparam logic [IDX_W-1:0] LAST = IDX_W'(N_MEM - 1);

   sched_st_e        state;
   logic [IDX_W-1:0] ptr;
   logic [IDX_W-1:0] cur;

   assign cur     = order_idx[ptr];
   assign clr     = (state == ST_IDLE) && start;
   assign capture = (state == ST_P1_WAIT);

   always_comb begin
      eng_start = '0;
      if (state == ST_P1_GO)      eng_start = '1;
      else if (state == ST_P2_GO) eng_start = N_MEM'(1) << cur;
   end
   assign ana_start = (state == ST_P2_GO);
   assign ana_sel   = cur;
   assign done      = (state == ST_DONE);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state    <= ST_IDLE;
         ptr      <= '0;
         all_pass <= 1'b0;
         rep      <= '0;
         irr      <= '0;
      end else begin
         unique case (state)
            ST_IDLE: if (start) begin
               state    <= ST_P1_GO;
               all_pass <= 1'b0;
               rep      <= '0;
               irr      <= '0;
            end
            ST_P1_GO:   state <= ST_P1_WAIT;
            ST_P1_WAIT: if (all_seen) state <= ST_EVAL;
            ST_EVAL: begin
               ptr <= '0;
               if (fail == '0) begin
                  all_pass <= 1'b1;
                  state    <= ST_DONE;
               end else begin
                  state <= ST_PICK;
               end
            end
            ST_PICK: begin
               if (fail[cur] && !over[cur]) state <= ST_P2_GO;
               else if (ptr == LAST)        state <= ST_DONE;
               else                         ptr   <= ptr + 1'b1;
            end
            ST_P2_GO:  state <= ST_P2_ENG;
            ST_P2_ENG: if (eng_done[cur]) state <= ST_P2_ANA;
            ST_P2_ANA: if (ana_done) begin
               rep[cur] <= ana_ok;
               irr[cur] <= !ana_ok;
               if (ptr == LAST) state <= ST_DONE;
               else begin
                  ptr   <= ptr + 1'b1;
                  state <= ST_PICK;
               end
            end
            ST_DONE: state <= ST_IDLE;
            default: state <= ST_IDLE;
         endcase
      end
   end

   a_r1_launch_all: assert property (@(posedge clk) disable iff (!rst_n)
      (state == ST_IDLE && start) |=> (eng_start == '1));
   a_r5_failed_only: assert property (@(posedge clk) disable iff (!rst_n)
      ana_start |-> (fail[ana_sel] && !over[ana_sel]));
   a_r6_one_engine: assert property (@(posedge clk) disable iff (!rst_n)
      ana_start |-> ($countones(eng_start) == 1 && eng_start[ana_sel]));
   a_r7_verdict: assert property (@(posedge clk) disable iff (!rst_n)
      (state == ST_P2_ANA && ana_done) |=>
         (rep[$past(ana_sel)] == $past(ana_ok) && irr[$past(ana_sel)] == !$past(ana_ok)));
   a_r8_done_pulse: assert property (@(posedge clk) disable iff (!rst_n)
      done |=> !done);
   a_r4_all_pass: assert property (@(posedge clk) disable iff (!rst_n)
      (done && all_pass) |-> (fail == '0));
endmodule

// File: rtl/mbs_sched.sv
module mbs_sched #(
   parameter int          N_MEM      = 4,
   parameter int          CNT_W      = 8,
   parameter int          SPARE_ROWS = 3,
   parameter int          SPARE_COLS = 3,
   parameter int unsigned MEM_WORDS [N_MEM] = '{256, 1024, 512, 1024},
   localparam int         IDX_W      = (N_MEM > 1) ? $clog2(N_MEM) : 1
) (
   input  logic                     clk,
   input  logic                     rst_n,
   input  logic                     start,
   output logic [N_MEM-1:0]         eng_start,
   input  logic [N_MEM-1:0]         eng_done,
   input  logic [N_MEM-1:0]         eng_fail,
   input  logic [N_MEM*CNT_W-1:0]   eng_fault_cnt,
   output logic                     ana_start,
   output logic [IDX_W-1:0]         ana_sel,
   input  logic                     ana_done,
   input  logic                     ana_ok,
   output logic                     done,
   output logic                     all_pass,
   output logic [N_MEM-1:0]         st_pass,
   output logic [N_MEM-1:0]         st_repaired,
   output logic [N_MEM-1:0]         st_irrep,
   output logic [N_MEM*CNT_W-1:0]   st_fault_cnt
);
   localparam int SPARES = SPARE_ROWS + SPARE_COLS;

   if (N_MEM < 1 || CNT_W < 1 || SPARES < 1) begin : g_bad_cfg
      $error("mbs_sched: N_MEM, CNT_W and spare total must be positive");
   end

   logic [N_MEM-1:0][IDX_W-1:0] order_idx;
   logic [N_MEM-1:0][CNT_W-1:0] cnt_in, cnt_q;
   logic [N_MEM-1:0]            seen, fail, over, rep, irr;
   logic                        all_seen, clr, capture;

   assign cnt_in       = eng_fault_cnt;
   assign st_fault_cnt = cnt_q;

   mbs_order #(.N_MEM(N_MEM), .IDX_W(IDX_W), .MEM_WORDS(MEM_WORDS)) u_order (
      .order_idx(order_idx)
   );

   mbs_collect #(.N_MEM(N_MEM), .CNT_W(CNT_W), .SPARES(SPARES)) u_collect (
      .clk(clk), .rst_n(rst_n), .clr(clr), .capture(capture),
      .eng_done(eng_done), .eng_fail(eng_fail), .eng_cnt(cnt_in),
      .seen(seen), .fail(fail), .over(over), .cnt(cnt_q), .all_seen(all_seen)
   );

   mbs_ctrl #(.N_MEM(N_MEM), .IDX_W(IDX_W)) u_ctrl (
      .clk(clk), .rst_n(rst_n), .start(start), .all_seen(all_seen),
      .fail(fail), .over(over), .order_idx(order_idx), .eng_done(eng_done),
      .ana_done(ana_done), .ana_ok(ana_ok), .clr(clr), .capture(capture),
      .eng_start(eng_start), .ana_start(ana_start), .ana_sel(ana_sel),
      .done(done), .all_pass(all_pass), .rep(rep), .irr(irr)
   );

   assign st_pass     = seen & ~fail;
   assign st_repaired = rep;
   assign st_irrep    = over | irr;

   // R3: a memory over the spare budget never reports a repair
   a_r3_over_not_repaired: assert property (@(posedge clk) disable iff (!rst_n)
      done |-> ((over & rep) == '0));
endmodule

// File: tb/mbs_sched_test.sv
`timescale 1ns/1ps
module mbs_sched_test;
   localparam int N = 4;
   localparam int CW = 8;
   localparam int SPARES = 6;
   localparam int unsigned SZ [N] = '{256, 1024, 512, 1024};

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic start = 1'b0;
   logic [N-1:0] eng_start, eng_done, eng_fail;
   logic [N*CW-1:0] eng_fault_cnt;
   logic ana_start, ana_done, ana_ok, done, all_pass;
   logic [1:0] ana_sel;
   logic [N-1:0] st_pass, st_repaired, st_irrep;
   logic [N*CW-1:0] st_fault_cnt;

   always #2 clk = ~clk;

   mbs_sched #(.N_MEM(N), .CNT_W(CW), .SPARE_ROWS(3), .SPARE_COLS(3), .MEM_WORDS(SZ)) uut (
      .clk(clk), .rst_n(rst_n), .start(start), .eng_start(eng_start),
      .eng_done(eng_done), .eng_fail(eng_fail), .eng_fault_cnt(eng_fault_cnt),
      .ana_start(ana_start), .ana_sel(ana_sel), .ana_done(ana_done), .ana_ok(ana_ok),
      .done(done), .all_pass(all_pass), .st_pass(st_pass), .st_repaired(st_repaired),
      .st_irrep(st_irrep), .st_fault_cnt(st_fault_cnt)
   );

   int n_chk = 0, n_bad = 0;
   int cyc = 0;
   int p1_cyc = -1, p1_cnt = 0, done_w = 0;
   int got_q[$];
   int lat [N];
   int ecnt [N];
   int acnt = 0;
   logic ok_of [N];
   logic f_of [N];
   int c_of [N];
   logic spur_req = 1'b0;
   int spur_idx = 0;

   task automatic check(input bit cond, input string tag, input longint act, input longint exp);
      n_chk++;
      if (!cond) begin
         n_bad++;
         $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
      end
   endtask

   // Behavioural engines, analyzer and per-cycle monitor
   initial begin
      eng_done = '0; ana_done = 1'b0; ana_ok = 1'b0;
      for (int i = 0; i < N; i++) ecnt[i] = 0;
      forever begin
         @(negedge clk);
         cyc++;
         if (done) done_w++;
         if (rst_n && eng_start == '1) begin
            p1_cyc = cyc; p1_cnt++;
         end else if (rst_n && eng_start != '0) begin
            for (int i = 0; i < N; i++) if (eng_start[i]) got_q.push_back(i);
            check($countones(eng_start) == 1, "R6 one engine", $countones(eng_start), 1);
            check(ana_start == 1'b1, "R6 ana_start with engine", ana_start, 1);
            check(eng_start[ana_sel] == 1'b1, "R6 ana_sel", ana_sel, got_q[$]);
         end
         for (int i = 0; i < N; i++) begin
            eng_done[i] = 1'b0;
            if (ecnt[i] != 0) begin
               ecnt[i]--;
               if (ecnt[i] == 0) eng_done[i] = 1'b1;
            end
            if (eng_start[i]) ecnt[i] = lat[i];
         end
         if (spur_req) begin
            eng_done[spur_idx] = 1'b1;
            spur_req = 1'b0;
         end
         ana_done = 1'b0;
         if (acnt != 0) begin
            acnt--;
            if (acnt == 0) begin
               ana_done = 1'b1;
               ana_ok = ok_of[ana_sel];
            end
         end
         if (ana_start) acnt = lat[ana_sel] + 2;
         for (int i = 0; i < N; i++) begin
            eng_fail[i] = f_of[i];
            eng_fault_cnt[i*CW +: CW] = CW'(c_of[i]);
         end
      end
   end

   task automatic run(input string name, input bit mid_start, input bit spur);
      int exp_q[$];
      bit used [N];
      int s_cyc, wd;
      bit any_fail = 0;
      for (int i = 0; i < N; i++) used[i] = 0;
      // Expected service list: descending size, lower index on ties
      for (int k = 0; k < N; k++) begin
         int best = -1;
         for (int i = 0; i < N; i++)
            if (!used[i] && (best < 0 || SZ[i] > SZ[best])) best = i;
         used[best] = 1;
         if (f_of[best] && c_of[best] <= SPARES) exp_q.push_back(best);
      end
      for (int i = 0; i < N; i++) any_fail |= f_of[i];
      got_q.delete(); p1_cnt = 0; done_w = 0;
      @(posedge clk); #1 start = 1'b1; s_cyc = cyc;
      @(posedge clk); #1 start = 1'b0;
      wd = 0;
      while (!done && wd < 3000) begin
         @(posedge clk); #1 wd++;
         if (mid_start && wd == 12) start = 1'b1;
         if (mid_start && wd == 13) start = 1'b0;
         if (spur && got_q.size() == 1 && !spur_req && wd < 40) begin
            spur_idx = exp_q[exp_q.size()-1]; spur_req = 1'b1; spur = 0;
         end
      end
      check(wd < 3000, {name, " watchdog"}, wd, 0);
      check(p1_cyc == s_cyc + 2, {name, " R1 launch cycle"}, p1_cyc, s_cyc + 2);
      check(p1_cnt == 1, {name, " R1/R8 single launch"}, p1_cnt, 1);
      check(all_pass == !any_fail, {name, " R4 all_pass"}, all_pass, !any_fail);
      check(got_q.size() == exp_q.size(), {name, " R5 service count"}, got_q.size(), exp_q.size());
      for (int k = 0; k < exp_q.size() && k < got_q.size(); k++)
         check(got_q[k] == exp_q[k], {name, " R5 order"}, got_q[k], exp_q[k]);
      for (int i = 0; i < N; i++) begin
         bit e_irr = f_of[i] && (c_of[i] > SPARES || !ok_of[i]);
         bit e_rep = f_of[i] && c_of[i] <= SPARES && ok_of[i];
         int e_cnt = f_of[i] ? c_of[i] : 0;
         check(st_pass[i] == !f_of[i], {name, " R2 pass"}, st_pass[i], !f_of[i]);
         check(st_fault_cnt[i*CW +: CW] == CW'(e_cnt), {name, " R2 count"}, st_fault_cnt[i*CW +: CW], e_cnt);
         check(st_irrep[i] == e_irr, {name, " R3/R7 irreparable"}, st_irrep[i], e_irr);
         check(st_repaired[i] == e_rep, {name, " R7 repaired"}, st_repaired[i], e_rep);
      end
      repeat (3) @(posedge clk);
      #1 check(done_w == 1, {name, " R8 done width"}, done_w, 1);
   endtask

   task automatic setmem(input int i, input logic f, input int c, input logic ok, input int l);
      f_of[i] = f; c_of[i] = c; ok_of[i] = ok; lat[i] = l;
   endtask

   initial begin
      for (int i = 0; i < N; i++) setmem(i, 0, 0, 1, 3 + i);
      repeat (3) @(posedge clk);
      #1 rst_n = 1'b1;
      @(posedge clk); #1;
      check(eng_start == '0 && !ana_start, "reset outputs idle", eng_start, 0);
      check(!done && !all_pass, "reset done/all_pass", {done, all_pass}, 0);
      check(st_pass == '0 && st_repaired == '0 && st_irrep == '0, "reset status", st_irrep, 0);

      // R4: clean run, no second pass
      run("S1", 0, 0);
      // R5 R7 R8 R9: three failures, mid-run start, spurious done
      setmem(0, 1, 2, 1, 2); setmem(1, 0, 0, 1, 5);
      setmem(2, 1, 5, 0, 4); setmem(3, 1, 4, 1, 3);
      run("S2", 1, 1);
      // R3: count 7 skipped, count 6 boundary still served
      setmem(0, 1, 1, 0, 3); setmem(1, 1, 7, 1, 2);
      setmem(2, 1, 6, 1, 6); setmem(3, 1, 3, 1, 1);
      run("S3", 0, 0);
      // R5: only the smallest memory fails
      setmem(0, 1, 6, 1, 4); setmem(1, 0, 0, 1, 2);
      setmem(2, 0, 0, 1, 3); setmem(3, 0, 0, 1, 1);
      run("S4", 0, 0);

      $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
      $finish;
   end
endmodule